// File: doc/BRIEF.md
# Lane Register-File Bank Arbiter

This block is the part of a vector lane that stores that lane's share of all vector registers. The storage is a set of single-ported 64-bit banks, each able to serve one read or one write per clock. Five sources request access. Three of them read operands (A, B and C), one reads the predicate mask and one writes results. Each source names a vector register and a word offset inside that register's slice of the lane. The block forms a lane word address from the two and splits it into a bank number and a row.

Each bank has its own fixed-order arbiter. The mask read goes first, then operand A, B and C, and the result write comes last. Every source whose bank is free is served in the same cycle. A read returns its word one clock later on the response lane of the bank that served it. The word comes with a tag that names the source. Each request port is valid/ready. A source raises `valid` and then holds it, with the same register, offset and write payload, until it sees `ready` high at a clock edge. `ready` depends on `valid` within the same cycle. The response lanes cannot be stalled, so the consumer must accept a word in the cycle it appears.

Top module: `lane_regbank_arb`

## Requirements
- R1: The lane word address of a request is `vreg * WPR + off`, where WPR is the number of 64-bit words a register occupies in one lane (VLEN / (64 * LANES), 16 by default). Bits [2:0] of that address pick the bank and the remaining upper bits pick the row. With the defaults, offset 0 of every register falls in bank 0, and offset k falls in bank k mod 8.
- R2: A bank serves at most one request per clock, read or write.
- R3: When several valid requests target one bank, the winner is fixed by source index: 0 mask read, 1 operand A, 2 operand B, 3 operand C, 4 result write. The lowest index wins.
- R4: Valid requests that target different banks are all granted in the same clock.
- R5: `req_ready[i]` is high only when `req_valid[i]` is high. A request that loses stays pending and is granted in a later cycle once no higher-priority request targets its bank. No request is lost.
- R6: A read granted at a clock edge makes `rsp_valid[b]` high in the following cycle, where b is the bank that served it. `rsp_data` lane b then holds the row content, and `rsp_tag` lane b (3 bits) holds the source index, which is 0 to 3.
- R7: A granted write (source 4) changes only those bytes of the addressed row whose bit in `wr_be` is 1. Bit j covers data bits [8j+7:8j]. A write raises no response.
- R8: After reset, all rows read as zero and no response lane is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 5 | Request valid, one bit per source (0 mask, 1 A, 2 B, 3 C, 4 write) |
| req_ready | output | 5 | Grant for each source in this cycle |
| req_vreg | input | 25 | Vector register number, 5 bits per source, source i at [5i+4:5i] |
| req_off | input | 20 | Word offset within the register slice, 4 bits per source |
| wr_data | input | 64 | Write data for source 4 |
| wr_be | input | 8 | Byte enables for source 4 |
| rsp_valid | output | 8 | Read response valid, one bit per bank |
| rsp_data | output | 512 | Read data, 64 bits per bank, bank b at [64b+63:64b] |
| rsp_tag | output | 24 | Source index of the response, 3 bits per bank |

## Verification
The bench uses the default parameters: VLEN 4096, four lanes, eight banks and 32 registers. That gives 16 words per register slice. Every register start therefore sits in bank 0, and offsets 0 and 8 of any two registers share a bank. This setting makes all-five conflicts easy to reach, both on purpose and under random traffic. Directed phases cover five sources aimed at one bank, five sources spread over five banks, and partial byte-enable writes. The random phase alternates between offsets drawn from {0, 8} and offsets drawn from the full range.

// File: rtl/lvrf_pkg.sv
package lvrf_pkg;
  localparam int unsigned N_SRC      = 5;
  localparam int unsigned N_READ_SRC = 4;
  localparam int unsigned SRC_W      = 3;

  typedef enum logic [SRC_W-1:0] {
    SRC_MASK = 3'd0,
    SRC_OPA  = 3'd1,
    SRC_OPB  = 3'd2,
    SRC_OPC  = 3'd3,
    SRC_WR   = 3'd4
  } src_e;
endpackage

// File: rtl/lvrf_addr_map.sv
module lvrf_addr_map #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned WPR    = 16,
  parameter int unsigned ADDR_W = 9,
  parameter int unsigned BANK_W = 3
) (
  input  logic [REG_W-1:0]         vreg,
  input  logic [OFF_W-1:0]         off,
  output logic [BANK_W-1:0]        bank,
  output logic [ADDR_W-BANK_W-1:0] row
);
  logic [ADDR_W-1:0] word;

  // register base = number times words per register slice
  assign word = ADDR_W'(vreg) * ADDR_W'(WPR) + ADDR_W'(off);
  assign bank = word[BANK_W-1:0];
  assign row  = word[ADDR_W-1:BANK_W];
endmodule

// File: rtl/lvrf_prio_pick.sv
module lvrf_prio_pick #(
  parameter int unsigned N     = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [N-1:0]     hit,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any
);
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    idx   = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (hit[i] && !found) begin
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        found    = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/lvrf_bank.sv
module lvrf_bank #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned ROWS   = 64,
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W/8-1:0] be,
  input  logic [TAG_W-1:0]  tag,
  output logic              rvalid,
  output logic [WORD_W-1:0] rdata,
  output logic [TAG_W-1:0]  rtag
);
  localparam int unsigned BE_W = WORD_W / 8;

  logic [WORD_W-1:0] mem [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(ROWS); i++) mem[i] <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
      rtag   <= '0;
    end else begin
      rvalid <= en && !we;
      if (en && !we) begin
        rdata <= mem[row];
        rtag  <= tag;
      end
      if (en && we) begin
        for (int j = 0; j < int'(BE_W); j++) begin
          if (be[j]) mem[row][j*8 +: 8] <= wdata[j*8 +: 8];
        end
      end
    end
  end
endmodule

// File: rtl/lane_regbank_arb.sv
module lane_regbank_arb
  import lvrf_pkg::*;
#(
  parameter  int unsigned VLEN      = 4096,
  parameter  int unsigned LANES     = 4,
  parameter  int unsigned NUM_VREGS = 32,
  parameter  int unsigned WORD_W    = 64,
  parameter  int unsigned NUM_BANKS = 8,
  localparam int unsigned WPR       = VLEN / (WORD_W * LANES),
  localparam int unsigned REG_W     = $clog2(NUM_VREGS),
  localparam int unsigned OFF_W     = (WPR > 1) ? $clog2(WPR) : 1,
  localparam int unsigned TOTAL_W   = NUM_VREGS * WPR,
  localparam int unsigned ADDR_W    = $clog2(TOTAL_W),
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS),
  localparam int unsigned ROW_W     = ADDR_W - BANK_W,
  localparam int unsigned ROWS      = TOTAL_W / NUM_BANKS,
  localparam int unsigned BE_W      = WORD_W / 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_SRC-1:0]             req_valid,
  output logic [N_SRC-1:0]             req_ready,
  input  logic [N_SRC*REG_W-1:0]       req_vreg,
  input  logic [N_SRC*OFF_W-1:0]       req_off,
  input  logic [WORD_W-1:0]            wr_data,
  input  logic [BE_W-1:0]              wr_be,
  output logic [NUM_BANKS-1:0]         rsp_valid,
  output logic [NUM_BANKS*WORD_W-1:0]  rsp_data,
  output logic [NUM_BANKS*SRC_W-1:0]   rsp_tag
);
  logic [BANK_W-1:0] bank_of [N_SRC];
  logic [ROW_W-1:0]  row_of  [N_SRC];
  logic [N_SRC-1:0]  grant_b [NUM_BANKS];

  // per-source address decode (R1)
  for (genvar r = 0; r < int'(N_SRC); r++) begin : g_map
    lvrf_addr_map #(
      .REG_W (REG_W),
      .OFF_W (OFF_W),
      .WPR   (WPR),
      .ADDR_W(ADDR_W),
      .BANK_W(BANK_W)
    ) u_map (
      .vreg(req_vreg[r*REG_W +: REG_W]),
      .off (req_off[r*OFF_W +: OFF_W]),
      .bank(bank_of[r]),
      .row (row_of[r])
    );
  end

  // one arbiter and one storage bank per bank index
  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    logic [N_SRC-1:0] hit;
    logic [SRC_W-1:0] idx;
    logic             any;
    logic             we;
    logic [ROW_W-1:0] row_sel;

    for (genvar r = 0; r < int'(N_SRC); r++) begin : g_hit
      assign hit[r] = req_valid[r] && (bank_of[r] == BANK_W'(b));
    end

    lvrf_prio_pick #(
      .N    (N_SRC),
      .IDX_W(SRC_W)
    ) u_pick (
      .hit  (hit),
      .grant(grant_b[b]),
      .idx  (idx),
      .any  (any)
    );

    always_comb begin
      row_sel = '0;
      for (int r = 0; r < int'(N_SRC); r++) begin
        if (grant_b[b][r]) row_sel = row_of[r];
      end
    end

    assign we = any && (idx == SRC_WR);

    lvrf_bank #(
      .WORD_W(WORD_W),
      .ROWS  (ROWS),
      .ROW_W (ROW_W),
      .TAG_W (SRC_W)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (any),
      .we    (we),
      .row   (row_sel),
      .wdata (wr_data),
      .be    (wr_be),
      .tag   (idx),
      .rvalid(rsp_valid[b]),
      .rdata (rsp_data[b*WORD_W +: WORD_W]),
      .rtag  (rsp_tag[b*SRC_W +: SRC_W])
    );
  end

  always_comb begin
    req_ready = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) req_ready = req_ready | grant_b[b];
  end
endmodule

// File: rtl/lvrf_arb_checker.sv
module lvrf_arb_checker
  import lvrf_pkg::*;
#(
  parameter  int unsigned VLEN      = 4096,
  parameter  int unsigned LANES     = 4,
  parameter  int unsigned NUM_VREGS = 32,
  parameter  int unsigned WORD_W    = 64,
  parameter  int unsigned NUM_BANKS = 8,
  localparam int unsigned WPR       = VLEN / (WORD_W * LANES),
  localparam int unsigned REG_W     = $clog2(NUM_VREGS),
  localparam int unsigned OFF_W     = (WPR > 1) ? $clog2(WPR) : 1,
  localparam int unsigned BE_W      = WORD_W / 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [N_SRC-1:0]            req_valid,
  input logic [N_SRC-1:0]            req_ready,
  input logic [N_SRC*REG_W-1:0]      req_vreg,
  input logic [N_SRC*OFF_W-1:0]      req_off,
  input logic [WORD_W-1:0]           wr_data,
  input logic [BE_W-1:0]             wr_be,
  input logic [NUM_BANKS-1:0]        rsp_valid,
  input logic [NUM_BANKS*WORD_W-1:0] rsp_data,
  input logic [NUM_BANKS*SRC_W-1:0]  rsp_tag
);
  int   cbank [N_SRC];
  logic multi_grant;
  logic prio_bad;
  logic missed;

  always_comb begin
    for (int r = 0; r < int'(N_SRC); r++) begin
      cbank[r] = (int'(req_vreg[r*REG_W +: REG_W]) * int'(WPR)
                  + int'(req_off[r*OFF_W +: OFF_W])) % int'(NUM_BANKS);
    end
    multi_grant = 1'b0;
    prio_bad    = 1'b0;
    missed      = 1'b0;
    for (int j = 0; j < int'(N_SRC); j++) begin
      logic blocked;
      blocked = 1'b0;
      for (int i = 0; i < j; i++) begin
        if (cbank[i] == cbank[j]) begin
          if (req_ready[i] && req_ready[j]) multi_grant = 1'b1;
          if (req_valid[i] && req_ready[j]) prio_bad = 1'b1;
          if (req_valid[i]) blocked = 1'b1;
        end
      end
      if (req_valid[j] && !blocked && !req_ready[j]) missed = 1'b1;
    end
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R5

  AST_STALL_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid != '0) |=> (($past(req_valid) & ~$past(req_ready) & ~req_valid) == '0)); // R5

  AST_ONE_PER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    !multi_grant); // R2

  AST_MASK_NEVER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |-> req_ready[0]); // R3

  AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    !prio_bad); // R3

  AST_FREE_BANK_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    !missed); // R4

  AST_RSP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready[N_READ_SRC-1:0] != '0) |=>
      ($countones(rsp_valid) == $countones($past(req_ready[N_READ_SRC-1:0])))); // R6

  AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready == 5'b10000) |=> (rsp_valid == '0)); // R7

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_tag
    AST_TAG_IS_READER: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[b] |-> (rsp_tag[b*SRC_W +: SRC_W] < SRC_W'(N_READ_SRC))); // R6
  end
endmodule

bind lane_regbank_arb lvrf_arb_checker #(
  .VLEN     (VLEN),
  .LANES    (LANES),
  .NUM_VREGS(NUM_VREGS),
  .WORD_W   (WORD_W),
  .NUM_BANKS(NUM_BANKS)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_vreg (req_vreg),
  .req_off  (req_off),
  .wr_data  (wr_data),
  .wr_be    (wr_be),
  .rsp_valid(rsp_valid),
  .rsp_data (rsp_data),
  .rsp_tag  (rsp_tag)
);

// File: tb/lane_regbank_arb_test.sv
module lane_regbank_arb_test;
  localparam int NS   = 5;
  localparam int NB   = 8;
  localparam int WPR  = 16;
  localparam int NW   = 32 * WPR;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [4:0]    req_valid;
  logic [4:0]    req_ready;
  logic [24:0]   req_vreg;
  logic [19:0]   req_off;
  logic [63:0]   wr_data;
  logic [7:0]    wr_be;
  logic [7:0]    rsp_valid;
  logic [511:0]  rsp_data;
  logic [23:0]   rsp_tag;

  lane_regbank_arb uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vreg(req_vreg), .req_off(req_off),
    .wr_data(wr_data), .wr_be(wr_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag)
  );

  always #2 clk = ~clk;

  bit          v   [NS];
  int          vr  [NS];
  int          of  [NS];
  bit          acc [NS];
  logic [63:0] wd = '0;
  logic [7:0]  wbe = '0;
  logic [63:0] mm  [NW];
  bit          e_rv [NB];
  logic [63:0] e_rd [NB];
  int          e_tg [NB];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  always_comb begin
    for (int r = 0; r < NS; r++) begin
      req_valid[r]         = v[r];
      req_vreg[r*5 +: 5]   = 5'(vr[r]);
      req_off[r*4 +: 4]    = 4'(of[r]);
    end
    wr_data = wd;
    wr_be   = wbe;
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < NW; i++) mm[i] = '0;
    for (int b = 0; b < NB; b++) begin e_rv[b] = 0; e_rd[b] = '0; e_tg[b] = 0; end
    for (int r = 0; r < NS; r++) begin v[r] = 0; vr[r] = 0; of[r] = 0; acc[r] = 0; end
  end

  // behavioural reference, compared every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      bit   g [NS];
      bit   taken [NB];
      logic [4:0] gv;
      for (int b = 0; b < NB; b++) begin
        check(rsp_valid[b] == e_rv[b], $sformatf("R6/R7 rsp_valid bank %0d", b),
              64'(rsp_valid[b]), 64'(e_rv[b]));
        if (e_rv[b]) begin
          check(rsp_data[b*64 +: 64] == e_rd[b], $sformatf("R1/R6/R7 rsp_data bank %0d", b),
                rsp_data[b*64 +: 64], e_rd[b]);
          check(int'(rsp_tag[b*3 +: 3]) == e_tg[b], $sformatf("R6 rsp_tag bank %0d", b),
                64'(rsp_tag[b*3 +: 3]), 64'(e_tg[b]));
        end
      end
      for (int b = 0; b < NB; b++) taken[b] = 0;
      gv = '0;
      for (int r = 0; r < NS; r++) begin
        int a;
        int bk;
        g[r] = 0;
        a  = vr[r] * WPR + of[r];
        bk = a % NB;
        if (v[r] && !taken[bk]) begin
          g[r] = 1; taken[bk] = 1; gv[r] = 1'b1;
        end
      end
      check(req_ready == gv, "R2/R3/R4/R5 req_ready", 64'(req_ready), 64'(gv));
      for (int b = 0; b < NB; b++) e_rv[b] = 0;
      for (int r = 0; r < NS; r++) begin
        int a;
        a = vr[r] * WPR + of[r];
        acc[r] = g[r];
        if (g[r] && r < 4) begin
          e_rv[a % NB] = 1; e_rd[a % NB] = mm[a]; e_tg[a % NB] = r;
        end
        if (g[r] && r == 4) begin
          for (int j = 0; j < 8; j++) if (wbe[j]) mm[a][j*8 +: 8] = wd[j*8 +: 8];
        end
      end
    end else begin
      for (int b = 0; b < NB; b++) e_rv[b] = 0;
      for (int r = 0; r < NS; r++) acc[r] = 0;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
    for (int r = 0; r < NS; r++) if (v[r] && acc[r]) v[r] = 0;
  endtask

  task automatic post(input int r, input int rg, input int o);
    v[r] = 1; vr[r] = rg; of[r] = o;
  endtask

  task automatic post_wr(input int rg, input int o, input logic [63:0] d, input logic [7:0] be);
    post(4, rg, o); wd = d; wbe = be;
  endtask

  task automatic drain();
    for (int k = 0; k < 50; k++) begin
      bit busy;
      busy = 0;
      for (int r = 0; r < NS; r++) busy |= v[r];
      if (!busy) break;
      step();
    end
    step(); step();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(rsp_valid == '0, "R8 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    check(req_ready == '0, "R8 req_ready idle", 64'(req_ready), 64'h0);
    // R8: fresh row reads zero
    step(); post(2, 9, 6); drain();

    // R1: write reg 3 offset 5 then read it back through the mask source
    step(); post_wr(3, 5, 64'hA5A5_1234_5678_9ABC, 8'hFF); drain();
    post(0, 3, 5); drain();

    // R7: partial byte enable, read back through operand B
    post_wr(3, 5, 64'h1111_2222_3333_4444, 8'h0F); drain();
    post(2, 3, 5); drain();

    // R3/R5: five sources on register starts, all in bank 0
    post(0, 1, 0); post(1, 2, 0); post(2, 3, 8); post(3, 4, 0);
    post_wr(5, 0, 64'hDEAD_BEEF_0BAD_F00D, 8'hF0);
    @(negedge clk);
    check(req_ready == 5'b00001, "R3 all five on bank 0", 64'(req_ready), 64'h1);
    drain();
    post(1, 5, 0); drain();

    // R4: five sources on five distinct banks
    post(0, 6, 0); post(1, 7, 1); post(2, 8, 2); post(3, 9, 3);
    post_wr(10, 4, 64'h0123_4567_89AB_CDEF, 8'h3C);
    @(negedge clk);
    check(req_ready == 5'b11111, "R4 distinct banks", 64'(req_ready), 64'h1F);
    drain();

    // R1: reg 0 offset 8 and reg 7 offset 0 share bank 0; offset 9 does not
    post(0, 7, 0); post(1, 0, 8); post(2, 0, 9);
    @(negedge clk);
    check(req_ready == 5'b00101, "R1 bank split", 64'(req_ready), 64'h5);
    drain();

    // random traffic, alternating conflict-heavy and spread offsets
    for (int c = 0; c < 4000; c++) begin
      bit hot;
      hot = ((c / 500) % 2) == 0;
      for (int r = 0; r < NS; r++) begin
        if (!v[r] && ($urandom % 2 == 1)) begin
          int o;
          o = hot ? int'(($urandom % 2) * 8) : int'($urandom % 16);
          if (r == 4) post_wr(int'($urandom % 32), o, {$urandom, $urandom}, 8'($urandom));
          else post(r, int'($urandom % 32), o);
        end
      end
      step();
    end
    drain();
    finish_run();
  end
endmodule